// File: doc/BRIEF.md
# Dual-Register Inverting Bus Bridge

This block connects two 8-bit ports, called A and B, in either direction. Each direction has a capture register of its own. The A-side register copies the A port when the A-to-B capture strobe rises. The B-side register copies the B port when the B-to-A capture strobe rises. A direction input and an active-low output enable choose which port, if any, the block drives. For each direction, a select input chooses what the driven port carries: the live value of the opposite port, or the value held in the register. Whatever the source, the value the block drives is the bitwise inverse of it.

Neither port is a tri-state pin. Each port is a set of three vectors: the value seen on the wire (input), the value the block would drive (output), and a per-bit drive enable. The capture strobes are asynchronous to the system clock. Each one passes through a synchroniser and a rising-edge detector before it loads its register. The port outputs are combinational in the control inputs, the live inputs and the two registers. A change of select, direction or output enable therefore appears on the outputs in the same cycle.

Streaming handshakes do not fit this block. The data path is level-based and always accepted, so there is no valid/ready and no back-pressure. A strobe edge is never held off.

Top module: `xcvr_bus_bridge`

## Requirements
- R1: While `rst` is high, both drive-enable vectors are all zero. The cycle after `rst` has been high, both capture registers hold zero.
- R2: A rising edge on `stb_ab` loads `a_in` into the A-side register. The strobe passes through two synchroniser flops and an edge flop. If `stb_ab` is high before clock edge 1, the register loads the `a_in` value sampled at clock edge 3 and shows it from then on.
- R3: `stb_ba` loads `b_in` into the B-side register with the same timing as R2.
- R4: Capture happens whatever the values of `oe_n` and `dir`, including isolation (`oe_n` = 1). Both registers can load in the same cycle.
- R5: When `oe_n` = 1, `a_oe` and `b_oe` are all zero. A port that is not driven has its data output at zero.
- R6: When `oe_n` = 0 and `dir` = 0, `a_oe` is all ones and `b_oe` is all zero. When `oe_n` = 0 and `dir` = 1, `b_oe` is all ones and `a_oe` is all zero.
- R7: When the A port is driven, `a_out` equals `~b_in` if `sel_ba` = 0, and equals the inverse of the B-side register if `sel_ba` = 1.
- R8: When the B port is driven, `b_out` equals `~a_in` if `sel_ab` = 0, and equals the inverse of the A-side register if `sel_ab` = 1.
- R9: A strobe held high causes one capture only. A change on the port while the strobe stays high leaves the register unchanged.
- R10: `a_oe` and `b_oe` are never non-zero at the same time. Each of them is always either all zero or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | B port source: 0 is live A, 1 is the A-side register |
| sel_ba | input | 1 | A port source: 0 is live B, 1 is the B-side register |
| stb_ab | input | 1 | Capture strobe for the A-side register (asynchronous) |
| stb_ba | input | 1 | Capture strobe for the B-side register (asynchronous) |
| a_in | input | W | Value seen on the A port |
| a_out | output | W | Value driven onto the A port |
| a_oe | output | W | Per-bit drive enable for the A port |
| b_in | input | W | Value seen on the B port |
| b_out | output | W | Value driven onto the B port |
| b_oe | output | W | Per-bit drive enable for the B port |

## Verification
The bench covers every combination of output enable, direction and the two selects. It compares each one against a model that tracks both registers. A swapped mux leg or a missing inverter shows up as data that is the true rather than the inverted source, or that comes from the wrong port.

Capture is checked in several settings: during isolation, on both strobes at once, and against the latency cycle by cycle. A design that gated capture with the output enable would keep stale data. A design with an extra or a missing stage would change the output one clock too late or too early.

A strobe is held high while the port data changes. A level-sensitive load would follow the new data instead of keeping the first value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    XFER_B_TO_A = 1'b0,
    XFER_A_TO_B = 1'b1
  } xfer_dir_e;

  localparam int unsigned LANE_AB = 0;
  localparam int unsigned LANE_BA = 1;
  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic rise_pulse
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_async};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_pulse = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] data_o,
  output logic [W-1:0] oe_o
);
  logic [W-1:0] src;

  always_comb begin
    src    = use_stored ? stored : live;
    data_o = en ? ~src : '0;
    oe_o   = {W{en}};
  end
endmodule

// File: rtl/xcvr_bus_bridge.sv
module xcvr_bus_bridge
  import xcvr_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [NUM_LANES-1:0] strobe_v;
  logic [NUM_LANES-1:0] load_v;
  logic [W-1:0]         cap_d [NUM_LANES];
  logic [W-1:0]         cap_q [NUM_LANES];

  assign strobe_v[LANE_AB] = stb_ab;
  assign strobe_v[LANE_BA] = stb_ba;
  assign cap_d[LANE_AB]    = a_in;
  assign cap_d[LANE_BA]    = b_in;

  // One synchroniser, edge detector and register per transfer lane
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    xcvr_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk          (clk),
      .rst          (rst),
      .strobe_async (strobe_v[g]),
      .rise_pulse   (load_v[g])
    );
    xcvr_capture_reg #(.W(W)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (load_v[g]),
      .d    (cap_d[g]),
      .q    (cap_q[g])
    );
  end

  logic         load_ab, load_ba;
  logic [W-1:0] store_ab_q, store_ba_q;
  assign load_ab    = load_v[LANE_AB];
  assign load_ba    = load_v[LANE_BA];
  assign store_ab_q = cap_q[LANE_AB];
  assign store_ba_q = cap_q[LANE_BA];

  // Reset forces isolation; at most one side is enabled
  logic drive_a, drive_b;
  always_comb begin
    drive_a = !rst && !oe_n && (xfer_dir_e'(dir) == XFER_B_TO_A);
    drive_b = !rst && !oe_n && (xfer_dir_e'(dir) == XFER_A_TO_B);
  end

  xcvr_port_drive #(.W(W)) u_drive_a (
    .en         (drive_a),
    .use_stored (sel_ba),
    .live       (b_in),
    .stored     (store_ba_q),
    .data_o     (a_out),
    .oe_o       (a_oe)
  );

  xcvr_port_drive #(.W(W)) u_drive_b (
    .en         (drive_b),
    .use_stored (sel_ab),
    .live       (a_in),
    .stored     (store_ab_q),
    .data_o     (b_out),
    .oe_o       (b_oe)
  );
endmodule

// File: rtl/xcvr_bus_bridge_chk.sv
module xcvr_bus_bridge_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         load_ab,
  input logic         load_ba,
  input logic [W-1:0] store_ab_q,
  input logic [W-1:0] store_ba_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (store_ab_q == '0 && store_ba_q == '0));

  // R1
  reset_isolates_chk: assert property (@(posedge clk)
    rst |-> (a_oe == '0 && b_oe == '0));

  // R2
  load_ab_data_chk: assert property (@(posedge clk) disable iff (rst)
    load_ab |=> store_ab_q == $past(a_in));

  // R3
  load_ba_data_chk: assert property (@(posedge clk) disable iff (rst)
    load_ba |=> store_ba_q == $past(b_in));

  // R9
  single_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_ab || load_ba) |=> !($past(load_ab) && load_ab) && !($past(load_ba) && load_ba));

  // R5
  isolation_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

  // R10
  one_side_chk: assert property (@(posedge clk) disable iff (rst)
    !((|a_oe) && (|b_oe)));

  // R10
  oe_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(a_oe) == 0 || &a_oe) && ($countones(b_oe) == 0 || &b_oe));

  // R7
  stored_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe[0] && sel_ba && $past(a_oe[0] && sel_ba) && !$past(load_ba)) |-> $stable(a_out));
endmodule

bind xcvr_bus_bridge xcvr_bus_bridge_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .oe_n       (oe_n),
  .sel_ba     (sel_ba),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe),
  .load_ab    (load_ab),
  .load_ba    (load_ba),
  .store_ab_q (store_ab_q),
  .store_ba_q (store_ba_q)
);

// File: tb/test_xcvr_bus_bridge.sv
module test_xcvr_bus_bridge;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, oe_n, dir, sel_ab, sel_ba, stb_ab, stb_ba;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

  always #10 clk = ~clk;

  xcvr_bus_bridge #(.W(W)) i_xcvr_bus_bridge (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .stb_ab(stb_ab), .stb_ba(stb_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] m_ab = '0;
  logic [W-1:0] m_ba = '0;

  // Expected {a_out, a_oe, b_out, b_oe}
  function automatic logic [4*W-1:0] expect_ports(
      logic oen, logic d, logic sab, logic sba,
      logic [W-1:0] ai, logic [W-1:0] bi, logic [W-1:0] rab, logic [W-1:0] rba);
    logic [W-1:0] ao, ae, bo, be;
    ao = '0; ae = '0; bo = '0; be = '0;
    if (!oen && !d) begin
      ae = '1; ao = sba ? ~rba : ~bi;
    end
    if (!oen && d) begin
      be = '1; bo = sab ? ~rab : ~ai;
    end
    return {ao, ae, bo, be};
  endfunction

  task automatic check_vec(string tag, logic [4*W-1:0] act, logic [4*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_ports(string tag);
    check_vec(tag, {a_out, a_oe, b_out, b_oe},
              expect_ports(oe_n, dir, sel_ab, sel_ba, a_in, b_in, m_ab, m_ba));
  endtask

  // Pulse the chosen strobes with the port data held steady; then update the model
  task automatic capture(bit do_ab, bit do_ba);
    @(negedge clk);
    stb_ab = do_ab; stb_ba = do_ba;
    repeat (4) @(negedge clk);
    stb_ab = 1'b0; stb_ba = 1'b0;
    if (do_ab) m_ab = a_in;
    if (do_ba) m_ba = b_in;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h1b2c_3d4e));
    rst = 1'b1; oe_n = 1'b0; dir = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    stb_ab = 1'b0; stb_ba = 1'b0; a_in = 8'h5a; b_in = 8'ha5;
    repeat (3) @(negedge clk);
    #2;
    // R1: enables off during reset even with oe_n low
    check_vec("R1 reset enables", {a_oe, b_oe}, '0);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: registers read back as zero via stored path
    check_vec("R1 reset A-port stored", {a_out, a_oe}, {8'hff, 8'hff});
    dir = 1'b1; #1;
    check_vec("R1 reset B-port stored", {b_out, b_oe}, {8'hff, 8'hff});

    // R2 latency: watch B port in stored mode
    @(negedge clk);
    a_in = 8'h3c; stb_ab = 1'b1;
    @(negedge clk); @(negedge clk);
    check_vec("R2 no load after two edges", {b_out}, {8'hff});
    @(negedge clk);
    check_vec("R2 load at third edge", {b_out}, {8'hc3});
    m_ab = 8'h3c;
    // R9: data changes while strobe stays high
    a_in = 8'h81;
    repeat (4) @(negedge clk);
    check_vec("R9 held strobe single capture", {b_out}, {8'hc3});
    stb_ab = 1'b0;
    repeat (3) @(negedge clk);

    // R3 latency: watch A port in stored mode
    dir = 1'b0; b_in = 8'h96; stb_ba = 1'b1;
    @(negedge clk); @(negedge clk);
    check_vec("R3 no load after two edges", {a_out}, {8'hff});
    @(negedge clk);
    check_vec("R3 load at third edge", {a_out}, {8'h69});
    m_ba = 8'h96;
    stb_ba = 1'b0;
    repeat (3) @(negedge clk);

    // R4: simultaneous capture while isolated
    oe_n = 1'b1; a_in = 8'h12; b_in = 8'hef;
    capture(1'b1, 1'b1);
    check_ports("R5 isolated after capture");
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
    check_vec("R4 A-side captured in isolation", {b_out}, {8'hed});
    dir = 1'b0; sel_ba = 1'b1; #1;
    check_vec("R4 B-side captured in isolation", {a_out}, {8'h10});

    // R6 R7 R8: every control combination, live data changing
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      {oe_n, dir, sel_ab, sel_ba} = 4'(c);
      a_in = 8'($urandom); b_in = 8'($urandom);
      #2;
      if (oe_n)     check_ports("R5 combination sweep");
      else if (dir) check_ports("R8 combination sweep");
      else          check_ports("R7 combination sweep");
    end

    // Random mix: R4 capture under random controls, R6 R7 R8 R10 observed
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      {oe_n, dir, sel_ab, sel_ba} = 4'($urandom);
      a_in = 8'($urandom); b_in = 8'($urandom);
      if (($urandom % 5) == 0) begin
        capture(1'($urandom), 1'($urandom));
      end
      #2;
      check_ports("R6 random");
      checks++;
      if ((|a_oe) && (|b_oe)) begin
        fails++;
        $display("FAIL R10 actual=%h/%h expected=one side", a_oe, b_oe);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule